// File: doc/BRIEF.md
# Amplifier Power Stage Fault Supervisor

This block watches the protection conditions of a two-channel switching power stage and decides when the stage may drive its load. It takes five kinds of fault source: three undervoltage flags (main supply, gate-drive charge pump, 5 V regulator), a per-output over-current flag, and a digitised junction temperature. Whenever any source is active it raises a fault indication, forces the audio path into mute and tristates every output.

Over-temperature has hysteresis. The block records a hot condition once the temperature code rises above a trip threshold. That condition is kept until the code falls below a lower clear threshold. Recovery needs no external reset. A one-second tick from the surrounding timebase triggers a restart attempt. If an undervoltage or hot condition is still present when the tick arrives, the attempt fails at once. Otherwise the outputs are re-enabled for a short probe window, with mute and fault still asserted. Over-current can only be sensed while the outputs drive, so a short still present during the window sends the block back to the tristated hold. A clean window returns the block to normal running.

A sticky cause register shows which sources were present when the most recent fault was entered. A clear strobe empties it.

Top module: `amp_fault_supervisor`

## Requirements
- R1: After reset, fault_out, force_mute and out_hiz are low and cause_status is zero.
- R2: Any undervoltage flag held high raises fault_out, force_mute and out_hiz on the third rising clock edge after it is applied (two synchroniser stages plus the state register), and not before.
- R3: The hot condition is set when the synchronised temperature code is strictly greater than TRIP_CODE, and a code equal to TRIP_CODE does not set it. A set hot condition forces the fault state.
- R4: The hot condition clears only when the code is strictly less than CLEAR_CODE. For codes from CLEAR_CODE to TRIP_CODE inclusive it keeps its previous value.
- R5: In the running state, an over-current flag on any one of the NUM_OUT outputs enters the fault state.
- R6: While the outputs are tristated, over-current flags are ignored: they neither release the fault nor change cause_status. The fault persists with no sec_tick, however long that lasts.
- R7: A sec_tick that arrives while an undervoltage or hot condition is present leaves out_hiz high.
- R8: A sec_tick with no undervoltage or hot condition present opens a probe window of exactly CHECK_CYC cycles, starting at the edge that samples the tick. During the window out_hiz is low while fault_out and force_mute stay high. Over-current seen during the window returns the block to out_hiz high. A clean window ends with all three outputs low.
- R9: cause_status bit 0 is main undervoltage, bit 1 is charge-pump undervoltage, bit 2 is regulator undervoltage, bit 3 is over-current on any output, and bit 4 is the hot condition. On each entry to the tristated hold, the register is loaded with the sources present at that moment. It holds its value until status_clr, which zeroes it. An entry in the same cycle as status_clr takes precedence.
- R10: out_hiz high always implies fault_out and force_mute high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_code | input | TEMP_W | Unsigned junction temperature code |
| ocp_flag | input | NUM_OUT | Over-current flag, one per output |
| uv_main | input | 1 | Main supply undervoltage |
| uv_pump | input | 1 | Charge pump undervoltage |
| uv_reg | input | 1 | 5 V regulator undervoltage |
| sec_tick | input | 1 | One-cycle pulse once per second (retry timebase) |
| status_clr | input | 1 | Clear strobe for cause_status |
| fault_out | output | 1 | Registered fault indication |
| force_mute | output | 1 | Mute request to the audio path |
| out_hiz | output | 1 | Tristate enable for all power outputs |
| cause_status | output | 5 | Sticky record of the sources present at the last fault entry |

## Verification
Each undervoltage flag and each over-current output is tried alone. This separates the sources by the cause bit they load, and it confirms the exact entry latency. The over-current cases keep the flag asserted across a retry, which shows the probe window opening and then closing one cycle later. Flags are also applied while tristated, to show they are ignored. The temperature is swept upward code by code through the trip point and then downward with a retry tick at each step. This separates the strict trip and clear comparisons from the hysteresis band in which the hot condition holds. A fault entry that coincides with a clear strobe shows which of the two wins.

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor #(
  parameter int TEMP_W     = 8,
  parameter int NUM_OUT    = 4,
  parameter int TRIP_CODE  = 155,
  parameter int CLEAR_CODE = 110,
  parameter int CHECK_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [NUM_OUT-1:0] ocp_flag,
  input  logic              uv_main,
  input  logic              uv_pump,
  input  logic              uv_reg,
  input  logic              sec_tick,
  input  logic              status_clr,
  output logic              fault_out,
  output logic              force_mute,
  output logic              out_hiz,
  output logic [4:0]        cause_status
);

  localparam int CNT_W = $clog2(CHECK_CYC + 1);
  localparam logic [TEMP_W-1:0] TRIP_T  = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] CLEAR_T = TEMP_W'(CLEAR_CODE);
  localparam logic [CNT_W-1:0]  LAST_C  = CNT_W'(CHECK_CYC - 1);

  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_PROBE} st_t;

  logic [2:0]         uv_m, uv_s;
  logic [NUM_OUT-1:0] oc_m, oc_s;
  logic [TEMP_W-1:0]  temp_m, temp_s;
  logic               ot_q;
  st_t                st, nxt;
  logic [CNT_W-1:0]   cnt;
  logic               fault_q, mute_q, hiz_q;
  logic [4:0]         cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_m <= '0; uv_s <= '0;
      oc_m <= '0; oc_s <= '0;
      temp_m <= '0; temp_s <= '0;
    end else begin
      uv_m <= {uv_reg, uv_pump, uv_main}; uv_s <= uv_m;
      oc_m <= ocp_flag;                   oc_s <= oc_m;
      temp_m <= temp_code;                temp_s <= temp_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ot_q <= 1'b0;
    else if (temp_s > TRIP_T)  ot_q <= 1'b1;
    else if (temp_s < CLEAR_T) ot_q <= 1'b0;
  end

  wire oc_any    = |oc_s;
  wire lvl_fault = (|uv_s) | ot_q;
  wire [4:0] cause_now = {ot_q, oc_any, uv_s};

  always_comb begin
    nxt = st;
    case (st)
      ST_RUN:   if (lvl_fault || oc_any) nxt = ST_HOLD;
      ST_HOLD:  if (sec_tick && !lvl_fault) nxt = ST_PROBE;
      ST_PROBE: if (lvl_fault || oc_any) nxt = ST_HOLD;
                else if (cnt == LAST_C) nxt = ST_RUN;
      default:  nxt = ST_HOLD;
    endcase
  end

  wire enter_hold = (st != ST_HOLD) && (nxt == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      cnt     <= '0;
      fault_q <= 1'b0;
      mute_q  <= 1'b0;
      hiz_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      st      <= nxt;
      cnt     <= (st == ST_PROBE && nxt == ST_PROBE) ? cnt + 1'b1 : '0;
      fault_q <= (nxt != ST_RUN);
      mute_q  <= (nxt != ST_RUN);
      hiz_q   <= (nxt == ST_HOLD);
      if (enter_hold)      cause_q <= cause_now;
      else if (status_clr) cause_q <= '0;
    end
  end

  assign fault_out    = fault_q;
  assign force_mute   = mute_q;
  assign out_hiz      = hiz_q;
  assign cause_status = cause_q;

endmodule

// File: rtl/amp_fault_supervisor_chk.sv
module amp_fault_supervisor_chk #(
  parameter int TEMP_W     = 8,
  parameter int TRIP_CODE  = 155,
  parameter int CLEAR_CODE = 110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic [TEMP_W-1:0] temp_s,
  input logic [2:0]        uv_s,
  input logic              ot_q,
  input logic              fault_out,
  input logic              force_mute,
  input logic              out_hiz
);

  localparam logic [TEMP_W-1:0] TRIP_T  = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] CLEAR_T = TEMP_W'(CLEAR_CODE);

  a_r3_trip_sets_hot: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_s > TRIP_T) |=> ot_q);

  a_r4_clear_below: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_s < CLEAR_T) |=> !ot_q);

  a_r4_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_s >= CLEAR_T && temp_s <= TRIP_T) |=> (ot_q == $past(ot_q)));

  a_r2_level_faults: assert property (@(posedge clk) disable iff (!rst_n)
    ((|uv_s) || ot_q) |=> fault_out);

  a_r7_retry_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_hiz && fault_out && $past(out_hiz)) |-> $past(sec_tick));

  a_r10_hiz_faulted: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> (fault_out && force_mute));

endmodule

bind amp_fault_supervisor amp_fault_supervisor_chk #(
  .TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE), .CLEAR_CODE(CLEAR_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .temp_s(temp_s),
  .uv_s(uv_s), .ot_q(ot_q), .fault_out(fault_out),
  .force_mute(force_mute), .out_hiz(out_hiz)
);

// File: tb/amp_fault_supervisor_bench.sv
module amp_fault_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TEMP_W = 8;
  localparam int NUM_OUT = 4;
  localparam int TRIP = 155;
  localparam int CLR = 110;
  localparam int CHK = 8;

  logic clk = 0, rst_n = 0;
  logic [TEMP_W-1:0] temp = 8'd25;
  logic [NUM_OUT-1:0] ocp = '0;
  logic [2:0] uv = '0;
  logic tick = 0, sclr = 0;
  logic fault_out, force_mute, out_hiz;
  logic [4:0] cause;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amp_fault_supervisor #(.TEMP_W(TEMP_W), .NUM_OUT(NUM_OUT), .TRIP_CODE(TRIP),
    .CLEAR_CODE(CLR), .CHECK_CYC(CHK)) u_amp_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .temp_code(temp), .ocp_flag(ocp),
    .uv_main(uv[0]), .uv_pump(uv[1]), .uv_reg(uv[2]), .sec_tick(tick),
    .status_clr(sclr), .fault_out(fault_out), .force_mute(force_mute),
    .out_hiz(out_hiz), .cause_status(cause));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic clear_status;
    @(negedge clk) sclr = 1;
    @(negedge clk) sclr = 0;
    chk("R9 cleared", cause, 0);
  endtask

  task automatic recover;
    cyc(4);
    pulse_tick();
    cyc(CHK);
    chk("R8 back to run", {fault_out, force_mute, out_hiz}, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 fault", fault_out, 0);
    chk("R1 mute", force_mute, 0);
    chk("R1 hiz", out_hiz, 0);
    chk("R1 cause", cause, 0);
    @(negedge clk) rst_n = 1;
    cyc(2);

    for (int i = 0; i < 3; i++) begin
      @(negedge clk) uv[i] = 1;
      cyc(2);
      chk("R2 not early", fault_out, 0);
      cyc(1);
      chk("R2 fault", fault_out, 1);
      chk("R2 mute", force_mute, 1);
      chk("R10 hiz", out_hiz, 1);
      chk("R9 uv cause", cause, 1 << i);
      ocp = 4'b0101;
      cyc(4);
      chk("R6 ocp ignored cause", cause, 1 << i);
      chk("R6 still hiz", out_hiz, 1);
      ocp = '0;
      cyc(3);
      pulse_tick();
      chk("R7 tick with uv", out_hiz, 1);
      uv[i] = 0;
      cyc(4);
      pulse_tick();
      chk("R8 window hiz", out_hiz, 0);
      chk("R8 window fault", fault_out, 1);
      chk("R8 window mute", force_mute, 1);
      cyc(CHK - 1);
      chk("R8 window end", fault_out, 1);
      cyc(1);
      chk("R8 run", {fault_out, force_mute, out_hiz}, 0);
      clear_status();
    end

    for (int j = 0; j < NUM_OUT; j++) begin
      @(negedge clk) ocp[j] = 1;
      cyc(3);
      chk("R5 ocp fault", out_hiz, 1);
      chk("R9 ocp cause", cause, 8);
      cyc(40);
      chk("R6 no tick stays", out_hiz, 1);
      pulse_tick();
      chk("R8 probe opens", out_hiz, 0);
      cyc(1);
      chk("R8 ocp in window", out_hiz, 1);
      @(negedge clk) ocp[j] = 0;
      recover();
      clear_status();
    end

    @(negedge clk) uv[0] = 1;
    cyc(2);
    sclr = 1;
    cyc(1);
    sclr = 0;
    chk("R9 entry beats clear", cause, 1);
    uv[0] = 0;
    recover();
    clear_status();

    for (int t = 100; t <= 170; t++) begin
      @(negedge clk) temp = TEMP_W'(t);
      cyc(5);
      chk("R3 rising", fault_out, (t > TRIP) ? 1 : 0);
      if (t == TRIP + 1) chk("R9 hot cause", cause, 16);
    end
    for (int t = 170; t >= 95; t--) begin
      @(negedge clk) temp = TEMP_W'(t);
      cyc(5);
      pulse_tick();
      cyc(CHK + 2);
      chk("R4 falling", fault_out, (t >= CLR) ? 1 : 0);
    end
    finish_run();
  end
endmodule